// File: doc/BRIEF.md
# Boot Image Authentication Sequencer

This block decides whether a processor may run the boot image that sits in flash. On a start request it picks one of five bank base addresses as the image entry point. It then reads the 16 KB that follow that address through a simple word-read port, one 32-bit read at a time. It groups the reads into 128-bit blocks and hands them to an external MAC engine over a valid/ready interface, flagging the final block. The MAC arithmetic itself lives in the engine. The block gives the engine a 128-bit key assembled from four 32-bit key registers.

The reference tag is stored inside the image it protects, so the sequencer captures those words as they stream past and substitutes all-ones for them in the blocks it sends. After the engine reports its tag, the two tags are compared. On a match the block reports pass and offers the entry point as the branch target. On a mismatch the outcome depends on the core role. A primary core raises a debug-halt request when an emulator is attached and locks until reset. A secondary core pulses a notification to the primary core and goes back to waiting for the next command.

Top module: `boot_auth_seq`

## Requirements
- R1: A start pulse in the idle state with bank_sel in 0..4 begins a run with entry point 0x0008_0000 + bank_sel*0x0002_0000, and busy is high from the next cycle until the verdict.
- R2: A run issues exactly 4096 single-cycle reads, one outstanding at a time, at addresses entry + 2*i for i = 0..4095 in ascending order. Each read waits for mem_rvalid, however many cycles that takes.
- R3: Each group of four consecutive reads forms one block with the first read in bits 127:96 and the fourth in bits 31:0. blk_valid, blk_data and blk_last hold until blk_ready, and blk_last is high only on the 1024th block.
- R4: The reads at entry + 2, +4, +6 and +8 are replaced by 0xFFFF_FFFF in the blocks sent to the engine.
- R5: The reference tag is taken from the raw reads at entry + 2, +4, +6 and +8, with the lowest address giving bits 127:96. It is compared with tag_data only in a cycle where tag_valid is high.
- R6: mac_key equals {key_w0, key_w1, key_w2, key_w3}, so key_w0 supplies the most significant word.
- R7: On a tag match, pass goes high and branch_addr equals the run's entry point; branch_addr is zero whenever pass is low.
- R8: On a mismatch with role_secondary low, fail goes high and stays high, busy stays low and later start pulses are ignored until reset. halt_req is high in that state exactly when emu_present is high.
- R9: On a mismatch with role_secondary high, fail goes high, notify_primary pulses for exactly one cycle, and the block returns to idle where a new start is accepted.
- R10: A start pulse while busy is ignored: the run in progress keeps its entry point and address sequence.
- R11: busy, pass and fail are never high together, all three are low after reset, and pass or fail holds until the next accepted start.
- R12: A start pulse with bank_sel of 5 or more is ignored: no read is issued and busy stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an authentication run |
| bank_sel | input | 3 | Bank index selecting the entry point |
| role_secondary | input | 1 | 1 = secondary core failure handling, 0 = primary |
| emu_present | input | 1 | Emulator attached; enables halt request |
| key_w0 | input | 32 | Key word, most significant |
| key_w1 | input | 32 | Key word |
| key_w2 | input | 32 | Key word |
| key_w3 | input | 32 | Key word, least significant |
| mem_rd | output | 1 | Read request, one cycle |
| mem_addr | output | 32 | Read address in 16-bit word units |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| mac_key | output | 128 | Key presented to the MAC engine |
| blk_valid | output | 1 | Block available to the engine |
| blk_ready | input | 1 | Engine accepts the block |
| blk_data | output | 128 | Block contents |
| blk_last | output | 1 | Final block of the image |
| tag_valid | input | 1 | Engine tag available |
| tag_data | input | 128 | Engine tag |
| busy | output | 1 | Run in progress |
| pass | output | 1 | Image authenticated |
| fail | output | 1 | Image rejected |
| branch_addr | output | 32 | Entry point on pass, else zero |
| halt_req | output | 1 | Debug halt request after primary failure |
| notify_primary | output | 1 | One-cycle failure notice from a secondary core |

## Verification
Assertions check every cycle that the status flags never overlap, that a stalled block stays unchanged, that reads happen only while busy, and that the blocks holding the tag location carry all-ones. They also check that the notification is a single pulse, that a pass follows a tag_valid cycle, and that the locked state persists. Only the bench scenarios can show the full address sequence and the block contents against an independent image model. The same holds for the pass/fail verdict against a separately computed expected tag, the per-bank entry points, the role- and emulator-dependent failure outcomes, and the rejection of start pulses while busy, after lockup or with an invalid bank.

// File: rtl/boot_auth_seq.sv
module boot_auth_seq #(
  parameter int          AW          = 32,
  parameter int          IMAGE_BYTES = 16384,
  parameter int          NBANK       = 5,
  parameter logic [31:0] BANK_BASE   = 32'h0008_0000,
  parameter logic [31:0] BANK_STRIDE = 32'h0002_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    bank_sel,
  input  logic          role_secondary,
  input  logic          emu_present,
  input  logic [31:0]   key_w0,
  input  logic [31:0]   key_w1,
  input  logic [31:0]   key_w2,
  input  logic [31:0]   key_w3,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata,
  output logic [127:0]  mac_key,
  output logic          blk_valid,
  input  logic          blk_ready,
  output logic [127:0]  blk_data,
  output logic          blk_last,
  input  logic          tag_valid,
  input  logic [127:0]  tag_data,
  output logic          busy,
  output logic          pass,
  output logic          fail,
  output logic [AW-1:0] branch_addr,
  output logic          halt_req,
  output logic          notify_primary
);
  localparam int NRD = IMAGE_BYTES / 4;
  localparam int IW  = $clog2(NRD);
  localparam logic [IW-1:0] TAG_LO = IW'(1);
  localparam logic [IW-1:0] TAG_HI = IW'(4);

  typedef enum logic [2:0] {S_IDLE, S_READ, S_WAIT, S_SEND, S_TAG, S_LOCK} st_t;

  st_t           st;
  logic [IW-1:0] idx;
  logic [AW-1:0] entry;
  logic [127:0]  gold;
  logic          pass_q, fail_q, notify_q;

  wire       in_tag = (idx >= TAG_LO) && (idx <= TAG_HI);
  wire [1:0] slot   = idx[1:0];
  wire [1:0] gsel   = 2'(idx - TAG_LO);
  wire       accept = start && (st == S_IDLE) && (32'(bank_sel) < NBANK);
  wire       at_end = (idx == IW'(NRD - 1));

  assign mac_key        = {key_w0, key_w1, key_w2, key_w3};
  assign mem_rd         = (st == S_READ);
  assign mem_addr       = entry + (AW'(idx) << 1);
  assign blk_valid      = (st == S_SEND);
  assign blk_last       = blk_valid && at_end;
  assign busy           = (st == S_READ) || (st == S_WAIT) || (st == S_SEND) || (st == S_TAG);
  assign pass           = pass_q;
  assign fail           = fail_q;
  assign branch_addr    = pass_q ? entry : '0;
  assign halt_req       = (st == S_LOCK) && emu_present;
  assign notify_primary = notify_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      idx      <= '0;
      entry    <= '0;
      blk_data <= '0;
      gold     <= '0;
      pass_q   <= 1'b0;
      fail_q   <= 1'b0;
      notify_q <= 1'b0;
    end else begin
      notify_q <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          entry  <= AW'(BANK_BASE + BANK_STRIDE * 32'(bank_sel));
          idx    <= '0;
          pass_q <= 1'b0;
          fail_q <= 1'b0;
          st     <= S_READ;
        end
        S_READ: st <= S_WAIT;
        S_WAIT: if (mem_rvalid) begin
          blk_data[(3 - slot) * 32 +: 32] <= in_tag ? 32'hFFFF_FFFF : mem_rdata;
          if (in_tag) gold[(3 - gsel) * 32 +: 32] <= mem_rdata;
          if (slot == 2'd3) st <= S_SEND;
          else begin
            idx <= idx + 1'b1;
            st  <= S_READ;
          end
        end
        S_SEND: if (blk_ready) begin
          if (at_end) st <= S_TAG;
          else begin
            idx <= idx + 1'b1;
            st  <= S_READ;
          end
        end
        S_TAG: if (tag_valid) begin
          if (tag_data == gold) begin
            pass_q <= 1'b1;
            st     <= S_IDLE;
          end else begin
            fail_q <= 1'b1;
            if (role_secondary) begin
              notify_q <= 1'b1;
              st       <= S_IDLE;
            end else st <= S_LOCK;
          end
        end
        S_LOCK: st <= S_LOCK;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy, pass, fail})); // R11
  AST_RD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> busy); // R2
  AST_BLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && !blk_ready |=> blk_valid && $stable(blk_data) && $stable(blk_last)); // R3
  AST_TAG_MASK_B0: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && (idx == IW'(3)) |-> blk_data[95:0] == {96{1'b1}}); // R4
  AST_TAG_MASK_B1: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && (idx == IW'(7)) |-> blk_data[127:96] == 32'hFFFF_FFFF); // R4
  AST_PASS_AFTER_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pass) |-> $past(tag_valid)); // R5
  AST_PASS_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
    !pass |-> branch_addr == '0); // R7
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOCK) |=> (st == S_LOCK) && fail && !busy); // R8
  AST_HALT_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> fail && emu_present); // R8
  AST_NOTIFY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    notify_primary |=> !notify_primary); // R9
endmodule

// File: tb/sim_boot_auth_seq.sv
module sim_boot_auth_seq;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst_n = 1'b0, start = 1'b0, role_secondary = 1'b0, emu_present = 1'b0;
  logic [2:0]   bank_sel = '0;
  logic [31:0]  key_w0 = 32'h2B7E_1516, key_w1 = 32'h28AE_D2A6, key_w2 = 32'hABF7_1588, key_w3 = 32'h09CF_4F3C;
  logic         mem_rd, mem_rvalid = 1'b0, blk_valid, blk_ready = 1'b0, blk_last, tag_valid = 1'b0;
  logic [31:0]  mem_addr, mem_rdata = '0, branch_addr;
  logic [127:0] mac_key, blk_data, tag_data = '0;
  logic         busy, pass, fail, halt_req, notify_primary;

  boot_auth_seq u0 (.*);

  int checks = 0, failures = 0;
  logic [31:0]  cur_entry = '0;
  logic [127:0] golden = '0;
  logic         clr = 1'b0;
  int nrd, nblk, addr_err, blk_err, last_err, notify_cnt, lat_cd, tag_cd, rdy_ph;
  logic [31:0]  pend;
  logic [127:0] acc;

  function automatic logic [31:0] img(input logic [31:0] a);
    return {a[23:8] ^ 16'h5A5A, a[15:0] ^ 16'h1F2E};
  endfunction
  function automatic logic [31:0] raw(input logic [31:0] a, input logic [31:0] e, input logic [127:0] g);
    logic [31:0] off = a - e;
    if (off == 2 || off == 4 || off == 6 || off == 8) return g[127 - 32*(int'(off)/2 - 1) -: 32];
    return img(a);
  endfunction
  function automatic logic [31:0] msk(input logic [31:0] a, input logic [31:0] e);
    logic [31:0] off = a - e;
    if (off == 2 || off == 4 || off == 6 || off == 8) return 32'hFFFF_FFFF;
    return img(a);
  endfunction
  function automatic logic [127:0] exp_blk(input logic [31:0] e, input int b);
    logic [31:0] a = e + 32'(8*b);
    return {msk(a, e), msk(a+2, e), msk(a+4, e), msk(a+6, e)};
  endfunction
  function automatic logic [127:0] exp_mac(input logic [31:0] e, input logic [127:0] k);
    logic [127:0] m = '0;
    for (int b = 0; b < 1024; b++) m = {m[126:0], m[127]} ^ exp_blk(e, b) ^ k;
    return m;
  endfunction

  always @(negedge clk) begin
    if (clr) begin
      nrd = 0; nblk = 0; addr_err = 0; blk_err = 0; last_err = 0; notify_cnt = 0;
      lat_cd = 0; tag_cd = 0; acc = '0;
    end
    if (notify_primary) notify_cnt++;
    mem_rvalid = 1'b0;
    if (lat_cd != 0) begin
      lat_cd--;
      if (lat_cd == 0) begin mem_rvalid = 1'b1; mem_rdata = raw(pend, cur_entry, golden); end
    end
    if (mem_rd) begin
      if (mem_addr != cur_entry + 32'(2*nrd)) addr_err++;
      pend = mem_addr; lat_cd = mem_addr[3] ? 2 : 1; nrd++;
    end
    tag_valid = 1'b0;
    if (tag_cd != 0) begin tag_cd--; if (tag_cd == 0) begin tag_valid = 1'b1; tag_data = acc; end end
    rdy_ph++;
    blk_ready = (rdy_ph % 3) != 0;
    if (blk_valid && blk_ready) begin
      if (blk_data != exp_blk(cur_entry, nblk)) blk_err++;
      if (blk_last != (nblk == 1023)) last_err++;
      acc = {acc[126:0], acc[127]} ^ blk_data ^ {key_w0, key_w1, key_w2, key_w3};
      if (blk_last) tag_cd = 3;
      nblk++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin failures++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; clr = 1'b1;
    repeat (3) @(negedge clk);
    clr = 1'b0; rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_start(input logic [2:0] b);
    bank_sel = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run(input logic [2:0] b, input bit good, input bit sec, input bit emu, input bit mid);
    cur_entry = 32'h0008_0000 + 32'h0002_0000 * 32'(b);
    golden = exp_mac(cur_entry, {key_w0, key_w1, key_w2, key_w3}) ^ (good ? 128'h0 : 128'h1);
    role_secondary = sec; emu_present = emu;
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    pulse_start(b);
    chk(busy === 1'b1 && pass === 1'b0 && fail === 1'b0, "R1 busy after start", {busy, pass, fail}, 3'b100);
    if (mid) begin repeat (200) @(negedge clk); pulse_start(3'd0); end
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(nrd == 4096, "R2 read count", nrd, 4096);
    chk(addr_err == 0, mid ? "R10 addresses after start while busy" : "R2 address order", addr_err, 0);
    chk(nblk == 1024, "R3 block count", nblk, 1024);
    chk(blk_err == 0, "R4 block contents with masked tag words", blk_err, 0);
    chk(last_err == 0, "R3 last flag", last_err, 0);
    if (good) begin
      chk(pass === 1'b1 && fail === 1'b0, "R5 tag match gives pass", {pass, fail}, 2'b10);
      chk(branch_addr == cur_entry, "R7 branch address", branch_addr, cur_entry);
    end else begin
      chk(fail === 1'b1 && pass === 1'b0, "R5 tag mismatch gives fail", {pass, fail}, 2'b01);
      chk(branch_addr == 0, "R7 no branch on fail", branch_addr, 0);
      chk(notify_cnt == (sec ? 1 : 0), sec ? "R9 one notify pulse" : "R8 no notify from primary", notify_cnt, sec);
      if (!sec) chk(halt_req === emu, "R8 halt follows emulator", halt_req, emu);
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk({busy, pass, fail} === 3'b000, "R11 reset status", {busy, pass, fail}, 0);
    chk(mac_key == {key_w0, key_w1, key_w2, key_w3}, "R6 key order", mac_key, {key_w0, key_w1, key_w2, key_w3});
    key_w0 = 32'h0011_2233; key_w3 = 32'hCCDD_EEFF;
    #1;
    chk(mac_key == {32'h0011_2233, key_w1, key_w2, 32'hCCDD_EEFF}, "R6 key MSW from word 0", mac_key,
        {32'h0011_2233, key_w1, key_w2, 32'hCCDD_EEFF});
  endtask

  task automatic t_bad_bank();
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    pulse_start(3'd5);
    repeat (6) @(negedge clk);
    chk(busy === 1'b0 && nrd == 0, "R12 invalid bank ignored", {busy, 31'(nrd)}, 0);
    chk(pass === 1'b1, "R11 pass holds across ignored start", pass, 1);
  endtask

  task automatic t_lock_ignores_start();
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    pulse_start(3'd1);
    repeat (6) @(negedge clk);
    chk(busy === 1'b0 && fail === 1'b1 && nrd == 0, "R8 locked state ignores start", {busy, fail, 30'(nrd)}, {2'b01, 30'd0});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    run(3'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    t_bad_bank();
    run(3'd4, 1'b1, 1'b0, 1'b0, 1'b1);
    run(3'd3, 1'b0, 1'b1, 1'b0, 1'b0);
    run(3'd2, 1'b1, 1'b1, 1'b0, 1'b0);
    run(3'd1, 1'b0, 1'b0, 1'b0, 1'b0);
    t_lock_ignores_start();
    do_reset();
    run(3'd1, 1'b0, 1'b0, 1'b1, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule